// File: doc/BRIEF.md
# Flash Write Status and Busy Engine

This block is the embedded-operation half of a behavioural flash model. A command decoder hands it a one-cycle start request for a word program, a sector erase, a block erase or a whole-array erase, together with the target address and, for a program, the word to write. The engine then holds a busy flag for a fixed, parameterised number of clock cycles chosen by the kind of operation. The busy flag goes back to the decoder.

While busy, every read strobe returns a status word instead of array data. Bit 7 is the polling bit: the inverse of bit 7 of the word being programmed, or 0 during any erase. Bit 6 flips on each read made while busy, starting from a cleared state at the start of the operation. The other bits repeat the last word read from the array before the operation began. When the operation ends, the engine raises a one-cycle update request that names the address range and the value the array must take, and later reads pass array data straight through again. The engine does not store the array itself.

Top module: `flash_wstat_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `upd_valid` and `rd_data` are all 0, and the toggle bit and the saved low-bit word are cleared.
- R2: A start accepted at a clock edge makes `busy` high from that edge for exactly T_PROG (default 28) cycles for a program, T_SECT (36) for a sector erase, T_BLK (36) for a block erase and T_CHIP (140) for a whole-array erase.
- R3: A start request sampled at an edge where `busy` is high is ignored: the running operation keeps its length, kind, range and data. A start sampled in the cycle where `upd_valid` is high is accepted.
- R4: When several start inputs are high at once, the whole-array erase wins over block erase, block over sector, and sector over program.
- R5: A read strobe sampled while a program is busy returns bit 7 of `rd_data` equal to the inverse of bit 7 of the word being programmed, one cycle after the strobe.
- R6: A read strobe sampled while any erase is busy returns bit 7 of `rd_data` equal to 0.
- R7: Bit 6 of the status word is 1 on the first read sampled while busy after a start and inverts on every further read while busy; cycles with no read strobe leave it unchanged.
- R8: While busy, bits other than 7 and 6 of the status word equal the same bits of the array word captured by the last read made while not busy (0 if none since reset).
- R9: A read strobe sampled while not busy loads `rd_data` with `arr_rdata` exactly, one cycle later.
- R10: One cycle after `busy` falls, `upd_valid` is high for exactly one cycle with `busy` low. For a program, `upd_is_erase`=0, `upd_lo`=`upd_hi`=the program address and `upd_data`=the programmed word. For an erase, `upd_is_erase`=1, `upd_data` is all ones, and the range is the start address rounded down to a multiple of SECT_WORDS (2048) up to the end of that sector, of BLK_WORDS (32768) likewise for a block, and 0 to all ones for a whole-array erase. The update fields are meaningful only while `upd_valid` is high.
- R11: In a cycle with no read strobe, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_prog | input | 1 | Start a word program (one-cycle pulse) |
| start_sect | input | 1 | Start a sector erase |
| start_blk | input | 1 | Start a block erase |
| start_chip | input | 1 | Start a whole-array erase |
| op_addr | input | ADDR_W | Target address of the operation being started |
| op_data | input | DATA_W | Word to program |
| rd_en | input | 1 | Read strobe |
| arr_rdata | input | DATA_W | Array word at the read address |
| busy | output | 1 | Operation in progress, returned to the command decoder |
| rd_data | output | DATA_W | Registered read result: array data or status word |
| upd_valid | output | 1 | One-cycle array update request at completion |
| upd_is_erase | output | 1 | Update is an erase (1) or a program (0) |
| upd_lo | output | ADDR_W | First address of the update range |
| upd_hi | output | ADDR_W | Last address of the update range |
| upd_data | output | DATA_W | Value the range must take |

## Verification
The hardest case to reach from the ports is a start request that lands exactly on the last busy edge, followed one cycle later by another start in the cycle where the completion request is raised. The first must be dropped and the second taken, so one misplaced count in the cycle timer flips both outcomes. The stimulus counts cycles from an accepted program to place the two requests on those two edges, and keeps reading with a random strobe density so that the toggle sequence, the polling bit and the frozen low bits are compared against a behavioural model on every clock across each kind of operation and across every priority combination used.

// File: rtl/fws_pkg.sv
// Shared types for the flash write status engine.
// Assumes: status bit positions are fixed by the polling protocol seen by software.
package fws_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } fws_op_e;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/fws_op_latch.sv
// Operation capture: resolves simultaneous start requests by priority,
// accepts one only while idle, and latches kind, target range and data.
// Assumes: SECT_WORDS and BLK_WORDS are powers of two no larger than 2**ADDR_W.
module fws_op_latch
    import fws_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int SECT_WORDS = 2048,
    parameter int BLK_WORDS  = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              start_prog,
    input  logic              start_sect,
    input  logic              start_blk,
    input  logic              start_chip,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    output logic              accept,
    output fws_op_e           acc_kind,
    output fws_op_e           kind_q,
    output logic [ADDR_W-1:0] lo_q,
    output logic [ADDR_W-1:0] hi_q,
    output logic [DATA_W-1:0] data_q
);
    localparam logic [ADDR_W-1:0] SECT_SPAN = ADDR_W'(SECT_WORDS - 1);
    localparam logic [ADDR_W-1:0] BLK_SPAN  = ADDR_W'(BLK_WORDS - 1);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] lo_d;
    logic [ADDR_W-1:0] hi_d;
    logic [DATA_W-1:0] data_d;

    // Priority pick: whole array over block over sector over program.
    always_comb begin
        if (start_chip)      acc_kind = OP_CHIP;
        else if (start_blk)  acc_kind = OP_BLK;
        else if (start_sect) acc_kind = OP_SECT;
        else                 acc_kind = OP_PROG;
    end

    assign accept = !busy && (start_prog || start_sect || start_blk || start_chip);

    // Range and target value for the picked kind.
    always_comb begin
        case (acc_kind)
            OP_SECT: span = SECT_SPAN;
            OP_BLK:  span = BLK_SPAN;
            OP_CHIP: span = '1;
            default: span = '0;
        endcase
        lo_d   = op_addr & ~span;
        hi_d   = op_addr | span;
        data_d = (acc_kind == OP_PROG) ? op_data : '1;
    end

    // Latch the accepted operation for status reads and the completion request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROG;
            lo_q   <= '0;
            hi_q   <= '0;
            data_q <= '0;
        end else if (accept) begin
            kind_q <= acc_kind;
            lo_q   <= lo_d;
            hi_q   <= hi_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/fws_timer.sv
// Busy timer: loads the cycle count of the accepted kind, holds busy for
// exactly that many cycles and pulses done in the cycle after busy falls.
// Assumes: every duration parameter is at least 1.
module fws_timer
    import fws_pkg::*;
#(
    parameter int T_PROG = 28,
    parameter int T_SECT = 36,
    parameter int T_BLK  = 36,
    parameter int T_CHIP = 140
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  fws_op_e acc_kind,
    output logic    busy,
    output logic    done
);
    localparam int T_ERA = (T_SECT > T_BLK) ? T_SECT : T_BLK;
    localparam int T_BIG = (T_CHIP > T_ERA) ? T_CHIP : T_ERA;
    localparam int T_MAX = (T_PROG > T_BIG) ? T_PROG : T_BIG;
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Remaining-cycle value to load for the accepted kind.
    always_comb begin
        case (acc_kind)
            OP_SECT: load_val = CNT_W'(T_SECT - 1);
            OP_BLK:  load_val = CNT_W'(T_BLK - 1);
            OP_CHIP: load_val = CNT_W'(T_CHIP - 1);
            default: load_val = CNT_W'(T_PROG - 1);
        endcase
    end

    // Count down while busy; release busy and flag completion at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (accept) begin
                busy <= 1'b1;
                cnt  <= load_val;
            end
        end
    end
endmodule

// File: rtl/fws_status_mux.sv
// Read path: passes array data when idle and builds the status word
// (polling bit, toggle bit, frozen low bits) while busy.
// Assumes: DATA_W is at least 8 so that the two status bit positions exist.
module fws_status_mux
    import fws_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              accept,
    input  logic              is_prog,
    input  logic              tgt_poll,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);
    logic              tog;
    logic [DATA_W-1:0] last_rd;
    logic [DATA_W-1:0] status_word;

    // Toggle state: cleared by a new operation, flipped by each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)             tog <= 1'b0;
        else if (accept)        tog <= 1'b0;
        else if (rd_en && busy) tog <= ~tog;
    end

    // Keep the last idle array word for the non-status bits.
    always_ff @(posedge clk) begin
        if (!rst_n)              last_rd <= '0;
        else if (rd_en && !busy) last_rd <= arr_rdata;
    end

    // Status word as it will appear after the flip of this read.
    always_comb begin
        status_word             = last_rd;
        status_word[POLL_BIT]   = is_prog ? ~tgt_poll : 1'b0;
        status_word[TOGGLE_BIT] = ~tog;
    end

    // Registered read result, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= busy ? status_word : arr_rdata;
    end
endmodule

// File: rtl/flash_wstat_engine.sv
// Top of the flash write status engine: wires operation capture, busy timer
// and read path, and presents the completion request to the array model.
// Assumes: start inputs are one-cycle pulses from the command decoder.
module flash_wstat_engine
    import fws_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int SECT_WORDS = 2048,
    parameter int BLK_WORDS  = 32768,
    parameter int T_PROG     = 28,
    parameter int T_SECT     = 36,
    parameter int T_BLK      = 36,
    parameter int T_CHIP     = 140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_sect,
    input  logic              start_blk,
    input  logic              start_chip,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              upd_valid,
    output logic              upd_is_erase,
    output logic [ADDR_W-1:0] upd_lo,
    output logic [ADDR_W-1:0] upd_hi,
    output logic [DATA_W-1:0] upd_data
);
    logic    accept;
    fws_op_e acc_kind;
    fws_op_e kind_q;
    logic    is_prog;

    fws_op_latch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SECT_WORDS(SECT_WORDS), .BLK_WORDS(BLK_WORDS)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .start_prog(start_prog), .start_sect(start_sect),
        .start_blk(start_blk), .start_chip(start_chip),
        .op_addr(op_addr), .op_data(op_data),
        .accept(accept), .acc_kind(acc_kind), .kind_q(kind_q),
        .lo_q(upd_lo), .hi_q(upd_hi), .data_q(upd_data)
    );

    fws_timer #(
        .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .accept(accept), .acc_kind(acc_kind),
        .busy(busy), .done(upd_valid)
    );

    assign is_prog      = (kind_q == OP_PROG);
    assign upd_is_erase = !is_prog;

    fws_status_mux #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
        .accept(accept), .is_prog(is_prog), .tgt_poll(upd_data[POLL_BIT]),
        .arr_rdata(arr_rdata), .rd_data(rd_data)
    );
endmodule

// File: rtl/flash_wstat_chk.sv
// Checker for the flash write status engine, attached by bind.
// Watches ports only; busy length is measured with a local counter.
module flash_wstat_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int T_PROG = 28,
    parameter int T_SECT = 36,
    parameter int T_BLK  = 36,
    parameter int T_CHIP = 140
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              upd_valid,
    input logic              upd_is_erase,
    input logic [ADDR_W-1:0] upd_lo,
    input logic [ADDR_W-1:0] upd_hi
);
    int run_len;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == T_PROG || run_len == T_SECT ||
                         run_len == T_BLK  || run_len == T_CHIP));

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (!busy && $past(busy)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    assert_range_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_lo <= upd_hi));

    assert_erase_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && upd_is_erase) |=> !rd_data[7]);

    assert_hold_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind flash_wstat_engine flash_wstat_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rd_data(rd_data),
    .upd_valid(upd_valid), .upd_is_erase(upd_is_erase),
    .upd_lo(upd_lo), .upd_hi(upd_hi)
);

// File: tb/flash_wstat_engine_tb.sv
// Bench: behavioural per-cycle model compared with the engine on every clock.
module flash_wstat_engine_tb;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int TP = 28, TS = 36, TB = 36, TC = 140;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_prog = 0, start_sect = 0, start_blk = 0, start_chip = 0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic rd_en = 0;
    logic [DW-1:0] arr_rdata = '0;
    logic busy, upd_valid, upd_is_erase;
    logic [DW-1:0] rd_data, upd_data;
    logic [AW-1:0] upd_lo, upd_hi;

    always #2.5 clk = ~clk;

    flash_wstat_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_sect(start_sect),
        .start_blk(start_blk), .start_chip(start_chip),
        .op_addr(op_addr), .op_data(op_data),
        .rd_en(rd_en), .arr_rdata(arr_rdata),
        .busy(busy), .rd_data(rd_data), .upd_valid(upd_valid),
        .upd_is_erase(upd_is_erase), .upd_lo(upd_lo), .upd_hi(upd_hi),
        .upd_data(upd_data)
    );

    int checks = 0;
    int errors = 0;
    string phase = "reset";
    int rd_mode = 0;   // 0 random, 1 every cycle, 2 never

    // Reference model state
    bit m_busy, m_upd, m_erase, m_tog;
    int m_left;
    logic [DW-1:0] m_rd, m_last, m_data;
    logic [AW-1:0] m_lo, m_hi;
    string t7 = "R1", t6 = "R1", tl = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_upd = 0; m_erase = 0; m_tog = 0; m_left = 0;
            m_rd = '0; m_last = '0; m_data = '0; m_lo = '0; m_hi = '0;
        end else begin
            if (rd_en) begin
                if (m_busy) begin
                    m_tog = ~m_tog;
                    m_rd = m_last;
                    m_rd[7] = m_erase ? 1'b0 : ~m_data[7];
                    m_rd[6] = m_tog;
                    t7 = m_erase ? "R6" : "R5"; t6 = "R7"; tl = "R8";
                end else begin
                    m_rd = arr_rdata;
                    m_last = arr_rdata;
                    t7 = "R9"; t6 = "R9"; tl = "R9";
                end
            end else begin
                t7 = "R11"; t6 = "R11"; tl = "R11";
            end
            m_upd = 0;
            if (m_busy) begin
                if (m_left == 1) begin m_busy = 0; m_upd = 1; end
                else m_left = m_left - 1;
            end else if (start_prog | start_sect | start_blk | start_chip) begin
                m_busy = 1; m_tog = 0;
                if (start_chip) begin
                    m_left = TC; m_erase = 1; m_lo = '0; m_hi = '1; m_data = '1;
                end else if (start_blk) begin
                    m_left = TB; m_erase = 1; m_data = '1;
                    m_lo = (op_addr / 32768) * 32768; m_hi = m_lo + 32767;
                end else if (start_sect) begin
                    m_left = TS; m_erase = 1; m_data = '1;
                    m_lo = (op_addr / 2048) * 2048; m_hi = m_lo + 2047;
                end else begin
                    m_left = TP; m_erase = 0; m_data = op_data;
                    m_lo = op_addr; m_hi = op_addr;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] act=%0h exp=%0h t=%0t", tag, phase, act, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "R2 busy", 32'(busy), 32'(m_busy));
            chk(upd_valid === m_upd, "R10 upd_valid", 32'(upd_valid), 32'(m_upd));
            if (m_upd) begin
                chk(upd_is_erase === m_erase, "R10 kind", 32'(upd_is_erase), 32'(m_erase));
                chk(upd_lo === m_lo, "R10 lo", 32'(upd_lo), 32'(m_lo));
                chk(upd_hi === m_hi, "R10 hi", 32'(upd_hi), 32'(m_hi));
                chk(upd_data === m_data, "R10 data", 32'(upd_data), 32'(m_data));
            end
            chk(rd_data[7] === m_rd[7], t7, 32'(rd_data[7]), 32'(m_rd[7]));
            chk(rd_data[6] === m_rd[6], t6, 32'(rd_data[6]), 32'(m_rd[6]));
            chk({rd_data[15:8], rd_data[5:0]} === {m_rd[15:8], m_rd[5:0]}, tl,
                32'(rd_data), 32'(m_rd));
        end
    end

    task automatic drive_read();
        case (rd_mode)
            1: rd_en = 1'b1;
            2: rd_en = 1'b0;
            default: rd_en = ($urandom_range(0, 2) != 0);
        endcase
        arr_rdata = DW'($urandom);
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            start_prog = 0; start_sect = 0; start_blk = 0; start_chip = 0;
            drive_read();
        end
    endtask

    task automatic go(bit p, bit s, bit b, bit c, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        start_prog = p; start_sect = s; start_blk = b; start_chip = c;
        op_addr = a; op_data = d;
        drive_read();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen right after release
        chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
        chk(upd_valid === 1'b0, "R1 upd_valid", 32'(upd_valid), 0);
        chk(rd_data === '0, "R1 rd_data", 32'(rd_data), 0);

        phase = "R9 R11 idle reads";
        run(20);

        phase = "R5 program poll high";
        go(1, 0, 0, 0, 18'h12345, 16'h5A3C); run(34);
        phase = "R5 R7 program poll low reads every cycle";
        rd_mode = 1;
        go(1, 0, 0, 0, 18'h00007, 16'h00A5); run(10);
        rd_mode = 2; run(8);            // R11 and R7: no reads, toggle frozen
        rd_mode = 1; run(14);
        rd_mode = 0;

        phase = "R6 R10 sector erase";
        go(0, 1, 0, 0, 18'h2ABCD, 16'h0000); run(40);
        phase = "R6 R10 block erase";
        go(0, 0, 1, 0, 18'h1F00F, 16'h0000); run(40);
        phase = "R6 R10 chip erase";
        go(0, 0, 0, 1, 18'h30001, 16'h0000); run(145);

        phase = "R3 start ignored on last busy edge then taken in done cycle";
        go(1, 0, 0, 0, 18'h00100, 16'h1234); run(27);
        go(0, 0, 0, 1, 18'h3FFFF, 16'h0000);
        go(0, 1, 0, 0, 18'h00900, 16'h0000); run(5);
        go(0, 0, 0, 1, 18'h00000, 16'h0000); run(40);   // R3 mid-run ignored

        phase = "R4 sector over program";
        go(1, 1, 0, 0, 18'h00FFF, 16'hFFFF); run(40);
        phase = "R4 chip over all";
        go(1, 1, 1, 1, 18'h20000, 16'hFFFF); run(145);
        phase = "R4 block over program";
        go(1, 0, 1, 0, 18'h0ABCD, 16'h0080); run(40);
        phase = "R9 after completion";
        run(10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule